// File: doc/BRIEF.md
# Parity-Protected Direct-Mapped Cache with Forced Refetch

This block is a small direct-mapped, write-through cache. It sits between a processor-side request port and a memory-side port. The memory side returns one 32-bit word per transfer. Each line holds one word. The tag store keeps a valid bit and a tag for each line, together with their parity. The data store keeps the word and its parity. Parity is generated whenever a tag entry or a data word is written, and it is checked on every lookup alongside the tag compare.

A lookup that would hit but finds a parity error in the tag entry or in the data word is handled as an ordinary miss. The word is fetched again from memory and the line is rewritten with fresh parity. Because every processor write also goes to memory, memory always holds a good copy. The refetch is therefore a complete repair, and it is invisible to the processor except for the extra cycles it takes.

A counter reports how many errors were repaired this way. A parameter selects the parity scheme. With one bit, parity covers the whole entry. With two bits, the even-numbered bits and the odd-numbered bits each carry their own parity bit, so a flip of two neighbouring bit cells is also caught.

Top module: `parity_cache`

## Requirements
- R1: After reset every line is invalid, `cpuReady` and `memReq` are low and `errCount` is zero; the first read of any address goes to memory.
- R2: A read miss holds `memReq` high with `memWe` low at `memAddr` = `cpuAddr` until `memAck`. The returned word is written into the line, and the read then completes with that word.
- R3: A read hit raises `cpuReady` with the cached word in the same cycle the request is presented and issues no memory request.
- R4: Every write is passed to memory (`memReq` and `memWe` high, same address and data) and completes only when `memAck` arrives.
- R5: A write that hits also updates the cached word and its parity, so a later read of that address hits and returns the new value.
- R6: A write that misses allocates no line: a later read of that address still goes to memory.
- R7: A single flipped bit in a cached data word turns the next read of it into a miss that returns the correct word from memory.
- R8: A flipped bit in a tag entry never yields a hit; the read is refetched from memory.
- R9: With the default two-bit parity (bit 0 covers even-numbered bits, bit 1 covers odd-numbered bits), a flip of two adjacent data bits is detected and refetched.
- R10: `errCount` rises by exactly one for each refetch caused by a parity error, does not change on ordinary misses, and saturates at its maximum.
- R11: After a refetch the line is clean again, and the next read of the same address hits.
- R12: The line index is the low `IDX_W` bits of the word address and the tag is the remaining upper bits. Two addresses with the same index evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request, held until `cpuReady` |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Word address |
| cpuWdata | input | DATA_W | Write data |
| cpuReady | output | 1 | Request completes at this clock edge |
| cpuRdata | output | DATA_W | Read data, valid with `cpuReady` on reads |
| memReq | output | 1 | Memory transfer request, held until `memAck` |
| memWe | output | 1 | 1 = memory write, 0 = refill read |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | DATA_W | Memory write data |
| memAck | input | 1 | Memory transfer done; carries refill data on reads |
| memRdata | input | DATA_W | Refill word |
| errCount | output | CNT_W | Saturating count of parity errors repaired by refetch |

## Verification
The main function is exercised with cold reads, repeated reads, write hits, write misses and conflicting addresses on one index. Together these separate a hit from a miss by the presence of a memory read and by the cycle in which the response arrives.

Faults are injected into the arrays from the bench: a single data bit flip, an adjacent double data flip and a tag bit flip. Each injection has to produce a refetch with correct data, a counter step and a clean hit afterwards. An ordinary miss that follows must leave the counter unchanged, which shows that it counts repairs rather than misses.

// File: rtl/pcache_pkg.sv
package pcache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_WRITE
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic fillWe;   // write tag entry and data word from refill
    logic hitWe;    // write data word from processor
  } dpStrobe_t;
endpackage

// File: rtl/pcache_par.sv
module pcache_par #(
  parameter int W  = 8,
  parameter int NB = 1
) (
  input  logic [W-1:0]  din,
  output logic [NB-1:0] par
);
  generate
    if (NB == 1) begin : g_one
      assign par = ^din;
    end else begin : g_two
      logic pe, po;
      always_comb begin
        pe = 1'b0;
        po = 1'b0;
        for (int i = 0; i < W; i += 2) pe ^= din[i];
        for (int i = 1; i < W; i += 2) po ^= din[i];
      end
      assign par = {po, pe};
    end
  endgenerate
endmodule

// File: rtl/pcache_dp.sv
module pcache_dp
  import pcache_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int IDX_W    = 4,
  parameter int DATA_W   = 32,
  parameter int PAR_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  dpStrobe_t         strobe,
  output logic              tagHit,
  output logic              hitRead,
  output logic              parErr,
  output logic [DATA_W-1:0] rdData
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int ENT_W = TAG_W + 1;

  logic [ENT_W-1:0]    tagRam  [LINES];
  logic [PAR_BITS-1:0] tagPar  [LINES];
  logic [DATA_W-1:0]   dataRam [LINES];
  logic [PAR_BITS-1:0] dataPar [LINES];

  logic [IDX_W-1:0]    idx;
  logic [TAG_W-1:0]    tag;
  logic [ENT_W-1:0]    entRd;
  logic [DATA_W-1:0]   wrData;
  logic [PAR_BITS-1:0] tagParCalc, dataParCalc, tagParNew, dataParNew;
  logic                tagErr, dataErr;

  assign idx    = addr[IDX_W-1:0];
  assign tag    = addr[ADDR_W-1:IDX_W];
  assign entRd  = tagRam[idx];
  assign rdData = dataRam[idx];
  assign wrData = strobe.fillWe ? memRdata : cpuWdata;

  pcache_par #(.W(ENT_W),  .NB(PAR_BITS)) uChkTag  (.din(entRd),       .par(tagParCalc));
  pcache_par #(.W(DATA_W), .NB(PAR_BITS)) uChkData (.din(rdData),      .par(dataParCalc));
  pcache_par #(.W(ENT_W),  .NB(PAR_BITS)) uGenTag  (.din({1'b1, tag}), .par(tagParNew));
  pcache_par #(.W(DATA_W), .NB(PAR_BITS)) uGenData (.din(wrData),      .par(dataParNew));

  assign tagErr  = tagParCalc != tagPar[idx];
  assign dataErr = dataParCalc != dataPar[idx];
  assign tagHit  = entRd[ENT_W-1] && (entRd[TAG_W-1:0] == tag) && !tagErr;
  assign hitRead = tagHit && !dataErr;
  assign parErr  = tagErr || (tagHit && dataErr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        tagRam[i] <= '0;
        tagPar[i] <= '0;
      end
    end else if (strobe.fillWe) begin
      tagRam[idx] <= {1'b1, tag};
      tagPar[idx] <= tagParNew;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillWe || strobe.hitWe) begin
      dataRam[idx] <= wrData;
      dataPar[idx] <= dataParNew;
    end
  end

  // R11: a refilled line looks up clean on the following cycle
  a_r11_fill_clean: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillWe |=> hitRead);

  // R5: a write hit leaves the new word readable as a hit
  a_r5_write_hit_update: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hitWe |=> (hitRead && rdData == $past(cpuWdata)));
endmodule

// File: rtl/pcache_ctrl.sv
module pcache_ctrl
  import pcache_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuReq,
  input  logic             cpuWe,
  input  logic             memAck,
  input  logic             tagHit,
  input  logic             hitRead,
  input  logic             parErr,
  output logic             cpuReady,
  output logic             memReq,
  output logic             memWe,
  output dpStrobe_t        strobe,
  output logic [CNT_W-1:0] errCount
);
  ctrlState_t state, nextState;
  logic       errPend;
  logic       readMiss;

  assign readMiss = (state == ST_IDLE) && cpuReq && !cpuWe && !hitRead;

  always_comb begin
    nextState = state;
    strobe    = '0;
    cpuReady  = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (cpuReq) begin
          if (cpuWe) begin
            strobe.hitWe = tagHit;
            nextState    = ST_WRITE;
          end else if (hitRead) begin
            cpuReady = 1'b1;
          end else begin
            nextState = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.fillWe = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      ST_WRITE: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          cpuReady  = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      errPend  <= 1'b0;
      errCount <= '0;
    end else begin
      state <= nextState;
      if (readMiss) errPend <= parErr;
      if ((state == ST_FILL) && memAck && errPend && (errCount != {CNT_W{1'b1}}))
        errCount <= errCount + 1'b1;
    end
  end

  // R2: a read miss starts a refill read on the next cycle
  a_r2_miss_fetches: assert property (@(posedge clk) disable iff (!rstN)
    readMiss |=> (memReq && !memWe));

  // R4: a write completes only together with the memory acknowledge
  a_r4_write_ack_from_mem: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReady && cpuWe) |-> memAck);

  // R4: a memory request is held steady until acknowledged
  a_r4_hold_req: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe)));

  // R3: a hit is served without touching memory
  a_r3_hit_no_mem: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReady && !cpuWe) |-> !memReq);

  // R10: the repair counter only steps up by one or holds
  a_r10_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (errCount == $past(errCount)) || (errCount == $past(errCount) + 1'b1));
endmodule

// File: rtl/parity_cache.sv
module parity_cache
  import pcache_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int IDX_W    = 4,
  parameter int DATA_W   = 32,
  parameter int PAR_BITS = 2,
  parameter int CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  output logic [CNT_W-1:0]  errCount
);
  dpStrobe_t strobe;
  logic      tagHit, hitRead, parErr;

  assign memAddr  = cpuAddr;
  assign memWdata = cpuWdata;

  pcache_dp #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .PAR_BITS(PAR_BITS)
  ) uDp (
    .clk(clk), .rstN(rstN), .addr(cpuAddr), .cpuWdata(cpuWdata),
    .memRdata(memRdata), .strobe(strobe), .tagHit(tagHit),
    .hitRead(hitRead), .parErr(parErr), .rdData(cpuRdata)
  );

  pcache_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .memAck(memAck),
    .tagHit(tagHit), .hitRead(hitRead), .parErr(parErr),
    .cpuReady(cpuReady), .memReq(memReq), .memWe(memWe),
    .strobe(strobe), .errCount(errCount)
  );
endmodule

// File: tb/tb_parity_cache.sv
`timescale 1ns/1ps
module tb_parity_cache;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0, cpuWe = 1'b0;
  logic [9:0]  cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic        cpuReady, memReq, memWe, memAck;
  logic [9:0]  memAddr;
  logic [31:0] memWdata, memRdata, cpuRdata;
  logic [7:0]  errCount;

  int compared = 0, mismatched = 0;
  int memReads = 0, memWrites = 0;
  int latCnt = 0;
  logic [31:0] memModel [1024];

  always #2.5 clk = ~clk;

  parity_cache dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuReady(cpuReady), .cpuRdata(cpuRdata),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata), .errCount(errCount)
  );

  // memory model: acknowledges after a short latency
  initial begin
    for (int i = 0; i < 1024; i++) memModel[i] = 32'h5A5A_0000 ^ (32'(i) * 32'h0001_0301);
    memAck = 1'b0;
    memRdata = '0;
    forever begin
      @(negedge clk);
      if (memAck) memAck = 1'b0;
      else if (memReq) begin
        if (latCnt == 2) begin
          latCnt = 0;
          memAck = 1'b1;
          if (memWe) begin
            memModel[memAddr] = memWdata;
            memWrites++;
          end else begin
            memRdata = memModel[memAddr];
            memReads++;
          end
        end else latCnt++;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [9:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int waits);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = wd; waits = 0;
    #1;
    while (!cpuReady) begin
      @(negedge clk); #1; waits++;
    end
    rd = cpuRdata;
    @(negedge clk);
    cpuReq = 1'b0; cpuWe = 1'b0;
  endtask

  localparam logic [9:0] ADDR_A = 10'h013;  // index 3, tag 1
  localparam logic [9:0] ADDR_B = 10'h023;  // index 3, tag 2
  localparam logic [9:0] ADDR_C = 10'h005;  // index 5

  task automatic testReset();
    logic [31:0] rd; int w, r0;
    chk("R1", "cpuReady after reset", 32'(cpuReady), 32'd0);
    chk("R1", "memReq after reset", 32'(memReq), 32'd0);
    chk("R1", "errCount after reset", 32'(errCount), 32'd0);
    r0 = memReads;
    access(1'b0, ADDR_A, '0, rd, w);
    chk("R1", "cold read goes to memory", 32'(memReads - r0), 32'd1);
    chk("R2", "refill data", rd, memModel[ADDR_A]);
  endtask

  task automatic testHit();
    logic [31:0] rd; int w, r0;
    r0 = memReads;
    access(1'b0, ADDR_A, '0, rd, w);
    chk("R3", "hit waits", 32'(w), 32'd0);
    chk("R3", "hit memory reads", 32'(memReads - r0), 32'd0);
    chk("R3", "hit data", rd, memModel[ADDR_A]);
  endtask

  task automatic testWriteHit();
    logic [31:0] rd; int w, r0, w0;
    w0 = memWrites;
    access(1'b1, ADDR_A, 32'hCAFE_1234, rd, w);
    chk("R4", "write passed to memory", 32'(memWrites - w0), 32'd1);
    chk("R4", "memory holds written word", memModel[ADDR_A], 32'hCAFE_1234);
    r0 = memReads;
    access(1'b0, ADDR_A, '0, rd, w);
    chk("R5", "read after write hit data", rd, 32'hCAFE_1234);
    chk("R5", "read after write hit no fetch", 32'(memReads - r0), 32'd0);
  endtask

  task automatic testWriteMiss();
    logic [31:0] rd; int w, r0, w0;
    w0 = memWrites;
    access(1'b1, ADDR_C, 32'h0BAD_F00D, rd, w);
    chk("R4", "write miss passed to memory", 32'(memWrites - w0), 32'd1);
    r0 = memReads;
    access(1'b0, ADDR_C, '0, rd, w);
    chk("R6", "no allocate on write miss", 32'(memReads - r0), 32'd1);
    chk("R6", "read after write miss data", rd, 32'h0BAD_F00D);
  endtask

  task automatic injectAndRead(input string req, input logic tagSide, input logic [31:0] mask,
                               input int expCount);
    logic [31:0] rd; int w, r0;
    @(negedge clk);
    if (tagSide) dut.uDp.tagRam[3] = dut.uDp.tagRam[3] ^ mask[6:0];
    else         dut.uDp.dataRam[3] = dut.uDp.dataRam[3] ^ mask;
    r0 = memReads;
    access(1'b0, ADDR_A, '0, rd, w);
    chk(req, "fault forces refetch", 32'(memReads - r0), 32'd1);
    chk(req, "refetched data", rd, memModel[ADDR_A]);
    chk("R10", "repair count", 32'(errCount), 32'(expCount));
    r0 = memReads;
    access(1'b0, ADDR_A, '0, rd, w);
    chk("R11", "clean hit after repair", 32'(memReads - r0), 32'd0);
    chk("R11", "clean hit waits", 32'(w), 32'd0);
  endtask

  task automatic testConflict();
    logic [31:0] rd; int w, r0;
    r0 = memReads;
    access(1'b0, ADDR_B, '0, rd, w);
    chk("R12", "conflicting address misses", 32'(memReads - r0), 32'd1);
    chk("R12", "conflicting address data", rd, memModel[ADDR_B]);
    chk("R10", "plain miss leaves count", 32'(errCount), 32'd3);
    r0 = memReads;
    access(1'b0, ADDR_A, '0, rd, w);
    chk("R12", "evicted address misses", 32'(memReads - r0), 32'd1);
    chk("R12", "evicted address data", rd, memModel[ADDR_A]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    testReset();
    testHit();
    testWriteHit();
    testWriteMiss();
    injectAndRead("R7", 1'b0, 32'h0000_0020, 1);  // single data bit
    injectAndRead("R9", 1'b0, 32'h0000_00C0, 2);  // adjacent bits 6 and 7
    injectAndRead("R8", 1'b1, 32'h0000_0001, 3);  // tag bit 0
    testConflict();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog (all requirements): actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule